// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block walks a programmable gate control list against a running precision time value and drives one gate-open line per transmit queue. Each 32-bit list word carries two fields: a duration in nanoseconds in the low bits and a gate mask in the bits above it. Enabling the block arms a schedule that begins at a programmed start time and repeats with a programmed period. The period is split into a seconds part and a nanoseconds part, and so is the start time.

If the programmed start time is not later than the time at which the schedule is armed, the block moves the start forward by whole periods. It starts on the first period boundary that lies strictly after the current time. Within a period the entries play in order from entry 0. The last entry's gates stay in force until the period ends. A period that ends early cuts the running entry short.

When a preemption mode is selected, bit 0 of the active gate mask also serves as a hold/release indication for frame preemption. While the block is disabled or misprogrammed, every gate is open and the preemption indication is low.

Top module: `tas_gate_sched`

## Requirements
- R1: A list word holds the interval in nanoseconds in bits [IVL_W-1:0] and the gate mask in bits [31:IVL_W]. Output gate_o[i] equals word bit IVL_W+i of the active entry.
- R2: The idle state is gate_o all ones and hold_o low. The block enters it one clock after any of these: reset, sched_en low, a start time of zero, a period of zero, list_len of zero, or list_len of DEPTH or more.
- R3: For a start time later than the time at arming, gate_o stays all ones until the time reaches the start time. Entry 0 takes effect at the clock that samples a time at or after the start time.
- R4: For a start time at or before the time at arming, the schedule begins at start + (n+1) × period, where n = floor((now − start) / period).
- R5: Entry i stays active for its interval in nanoseconds, measured from the end of entry i−1 (or from the period start for entry 0). Entry i+1 then takes over.
- R6: Once the last used entry (list_len−1) expires, its gate mask stays on gate_o until the period ends.
- R7: When a full period has elapsed since the period start, entry 0 is reloaded even if the active entry has not expired.
- R8: While a schedule is running, hold_o equals preempt_mode AND gate bit 0 of the active entry. hold_o is low in every other state.
- R9: Times are carried as 32-bit seconds plus a nanosecond count below 10^9. Every sum carries into seconds at 10^9, so schedules run correctly across a second boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sched_en | input | 1 | Arms the schedule while high |
| preempt_mode | input | 1 | Uses gate bit 0 as the preemption hold indication |
| now_sec | input | 32 | Current time, seconds |
| now_ns | input | 30 | Current time, nanoseconds (below 10^9) |
| base_sec | input | 32 | Schedule start time, seconds |
| base_ns | input | 30 | Schedule start time, nanoseconds |
| cycle_sec | input | 32 | Schedule period, seconds |
| cycle_ns | input | 30 | Schedule period, nanoseconds (below 10^9) |
| list_len | input | ADDR_W+1 | Number of used list entries |
| wr_en | input | 1 | List write strobe |
| wr_addr | input | ADDR_W | List write index |
| wr_data | input | 32 | List write word |
| gate_o | output | 32-IVL_W | Per-queue gate-open vector |
| hold_o | output | 1 | Preemption hold (1) or release (0) |

## Verification
The hardest situation to reach is a start time in the past. Here the block must step forward by whole periods while the time input keeps advancing. The step count must land on the same boundary that the closed-form formula gives. The bench arms schedules whose start lies a random two periods plus an offset behind the current time, and also places starts exactly on a period boundary. It advances the time one nanosecond per clock and runs the time across a second boundary. Random periods are chosen both shorter and longer than the sum of the intervals, so early truncation and the hold of the last entry both occur.

// File: rtl/tas_pkg.sv
package tas_pkg;
    localparam int unsigned NS_PER_SEC = 1_000_000_000;
    localparam int NS_W  = 30;
    localparam int SEC_W = 32;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } ptp_time_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SEEK,
        ST_WAIT,
        ST_RUN,
        ST_TAIL
    } sched_st_e;
endpackage

// File: rtl/tas_time_add.sv
module tas_time_add
    import tas_pkg::*;
(
    input  ptp_time_t a,
    input  ptp_time_t b,
    output ptp_time_t sum
);
    logic [NS_W:0] ns_raw;
    logic          wrap;

    always_comb begin
        ns_raw  = {1'b0, a.ns} + {1'b0, b.ns};
        wrap    = ns_raw >= (NS_W+1)'(NS_PER_SEC);
        sum.sec = a.sec + b.sec + SEC_W'(wrap);
        sum.ns  = wrap ? NS_W'(ns_raw - (NS_W+1)'(NS_PER_SEC)) : ns_raw[NS_W-1:0];
    end
endmodule

// File: rtl/tas_gcl_mem.sv
module tas_gcl_mem #(
    parameter int DEPTH   = 64,
    parameter int ENTRY_W = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);
    logic [ENTRY_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
    import tas_pkg::*;
#(
    parameter int IVL_W   = 24,
    parameter int DEPTH   = 64,
    parameter int ENTRY_W = 32,
    localparam int GATE_W = ENTRY_W - IVL_W,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sched_en,
    input  logic               preempt_mode,
    input  logic [31:0]        now_sec,
    input  logic [29:0]        now_ns,
    input  logic [31:0]        base_sec,
    input  logic [29:0]        base_ns,
    input  logic [31:0]        cycle_sec,
    input  logic [29:0]        cycle_ns,
    input  logic [LEN_W-1:0]   list_len,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic [GATE_W-1:0]  gate_o,
    output logic               hold_o
);
    typedef struct packed {
        sched_st_e         st;
        ptp_time_t         start;
        ptp_time_t         ent_end;
        logic [ADDR_W-1:0] idx;
        logic [GATE_W-1:0] gates;
        logic              hold;
    } regs_t;

    regs_t r_d, r_q;

    ptp_time_t          now, base, cyc, cyc_next, load_base, load_end, ivl_t;
    logic [ADDR_W-1:0]  rd_idx;
    logic [ENTRY_W-1:0] rd_data;
    logic               cfg_ok, running, restart, load_first, expired, last;

    initial begin
        assert (IVL_W < NS_W && IVL_W > 0) else $error("IVL_W out of range");
    end

    assign now  = '{sec: now_sec,   ns: now_ns};
    assign base = '{sec: base_sec,  ns: base_ns};
    assign cyc  = '{sec: cycle_sec, ns: cycle_ns};

    tas_gcl_mem #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_idx),
        .rd_data (rd_data)
    );

    // Period boundary: start of the current (or pending) cycle plus the period
    tas_time_add u_add_cyc (.a(r_q.start), .b(cyc), .sum(cyc_next));
    // End of the entry about to be loaded
    tas_time_add u_add_ivl (.a(load_base), .b(ivl_t), .sum(load_end));

    always_comb begin
        cfg_ok     = sched_en && (base != '0) && (cyc != '0) &&
                     (list_len != '0) && (list_len < LEN_W'(DEPTH));
        running    = (r_q.st == ST_RUN) || (r_q.st == ST_TAIL);
        restart    = running && (now >= cyc_next);
        load_first = ((r_q.st == ST_WAIT) && (now >= r_q.start)) || restart;
        load_base  = restart ? cyc_next :
                     ((r_q.st == ST_WAIT) ? r_q.start : r_q.ent_end);
        rd_idx     = load_first ? '0 : r_q.idx + ADDR_W'(1);
        ivl_t      = '{sec: '0, ns: NS_W'(rd_data[IVL_W-1:0])};
        expired    = now >= r_q.ent_end;
        last       = r_q.idx == ADDR_W'(list_len - LEN_W'(1));

        r_d = r_q;
        if (!cfg_ok) begin
            r_d.st = ST_OFF;
        end else begin
            unique case (r_q.st)
                ST_OFF: begin
                    r_d.st    = ST_SEEK;
                    r_d.start = base;
                end
                ST_SEEK: begin
                    if (now >= r_q.start) r_d.start = cyc_next;
                    else                  r_d.st    = ST_WAIT;
                end
                ST_WAIT, ST_RUN, ST_TAIL: begin
                    if (restart) r_d.start = cyc_next;
                    if (load_first || ((r_q.st == ST_RUN) && expired && !last)) begin
                        r_d.st      = ST_RUN;
                        r_d.idx     = rd_idx;
                        r_d.ent_end = load_end;
                        r_d.gates   = rd_data[ENTRY_W-1:IVL_W];
                    end else if ((r_q.st == ST_RUN) && expired && last) begin
                        r_d.st = ST_TAIL;
                    end
                end
                default: r_d.st = ST_OFF;
            endcase
        end

        if (!((r_d.st == ST_RUN) || (r_d.st == ST_TAIL))) begin
            r_d.gates = '1;
            r_d.hold  = 1'b0;
        end else begin
            r_d.hold  = preempt_mode & r_d.gates[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_OFF, start: '0, ent_end: '0, idx: '0, gates: '1, hold: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_o = r_q.gates;
    assign hold_o = r_q.hold;

    // R2: a clock after the schedule is not armed, all gates are open
    assert_off_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_ok) |-> (gate_o == '1 && !hold_o));

    // R8: a hold indication only follows a sampled preemption mode
    assert_hold_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> $past(preempt_mode));

    // R4: the search for the first boundary only moves forward
    assert_seek_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEEK && cfg_ok && now >= r_q.start) |=> (r_q.start > $past(r_q.start)));

    // R5: an entry never ends before the cycle it belongs to began
    assert_entry_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |-> (r_q.ent_end >= r_q.start));

    // R6: in the tail of a cycle the gates do not move until a restart
    assert_tail_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TAIL && cfg_ok && !restart) |=> $stable(gate_o));

    // R9: stored times stay normalised below one second of nanoseconds
    assert_ns_norm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.start.ns < NS_W'(NS_PER_SEC)) && (r_q.ent_end.ns < NS_W'(NS_PER_SEC)));
endmodule

// File: tb/tas_gate_sched_tb.sv
`timescale 1ns/1ps
module tas_gate_sched_tb;
    localparam int IVL_W  = 24;
    localparam int DEPTH  = 64;
    localparam int GATE_W = 32 - IVL_W;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int LEN_W  = ADDR_W + 1;
    localparam longint unsigned BIL = 64'd1_000_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sched_en = 1'b0, preempt_mode = 1'b0;
    logic [31:0] now_sec = '0, base_sec = '0, cycle_sec = '0;
    logic [29:0] now_ns = '0, base_ns = '0, cycle_ns = '0;
    logic [LEN_W-1:0] list_len = '0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [GATE_W-1:0] gate_o;
    logic hold_o;

    int n_chk = 0, n_fail = 0;

    // bench model state
    longint unsigned t;
    longint unsigned m_s, m_c;
    bit m_act, m_past, m_pm;
    int m_len;
    int m_ivl [8];
    logic [GATE_W-1:0] m_g [8];

    tas_gate_sched #(.IVL_W(IVL_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .sched_en(sched_en), .preempt_mode(preempt_mode),
        .now_sec(now_sec), .now_ns(now_ns), .base_sec(base_sec), .base_ns(base_ns),
        .cycle_sec(cycle_sec), .cycle_ns(cycle_ns), .list_len(list_len),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gate_o(gate_o), .hold_o(hold_o)
    );

    always #10 clk = ~clk;

    initial begin
        #(20.0 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic longint unsigned first_start(longint unsigned b, longint unsigned now,
                                                    longint unsigned c);
        if (b > now) return b;
        return b + ((now - b) / c + 1) * c;   // R4 closed form
    endfunction

    function automatic void model(input longint unsigned tt, output logic [GATE_W-1:0] g,
                                  output logic h, output string lbl);
        longint unsigned k, cum;
        int idx;
        bit found;
        g = '1; h = 1'b0;
        if (!m_act) begin lbl = "R2"; return; end
        if (tt < m_s) begin lbl = m_past ? "R4" : "R3"; return; end
        k = (tt - m_s) % m_c;
        cum = 0; found = 0; idx = 0;
        for (int i = 0; i < m_len; i++) begin
            cum += longint'(m_ivl[i]);
            if (!found && k < cum) begin found = 1; idx = i; end
        end
        if (!found) begin g = m_g[m_len-1]; lbl = "R6"; end
        else begin
            g = m_g[idx];
            lbl = ((tt - m_s) >= m_c && idx == 0) ? "R7" : "R5";
        end
        if ((tt / BIL) != (m_s / BIL)) lbl = {lbl, "+R9"};
        h = m_pm & g[0];
    endfunction

    task automatic drive_time();
        now_sec = 32'(t / BIL);
        now_ns  = 30'(t % BIL);
    endtask

    task automatic check_now();
        logic [GATE_W-1:0] eg;
        logic eh;
        string lbl;
        model(t, eg, eh, lbl);
        n_chk++;
        if (gate_o !== eg) begin
            n_fail++;
            $display("FAIL %s gate (R1 field map) t=%0d got %h exp %h", lbl, t, gate_o, eg);
        end
        n_chk++;
        if (hold_o !== eh) begin
            n_fail++;
            $display("FAIL R8 hold (%s) t=%0d got %0b exp %0b", lbl, t, hold_o, eh);
        end
    endtask

    // one clock: check outputs for the time sampled at the last edge, then advance time
    task automatic tick(input bit chk);
        @(negedge clk);
        if (chk) check_now();
        t = t + 1;
        drive_time();
    endtask

    task automatic put(input int a, input logic [31:0] d);
        tick(1'b1);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    endtask

    task automatic set_times(input longint unsigned b, input longint unsigned c);
        base_sec  = 32'(b / BIL); base_ns  = 30'(b % BIL);
        cycle_sec = 32'(c / BIL); cycle_ns = 30'(c % BIL);
    endtask

    task automatic disarm();
        tick(1'b1);
        sched_en = 1'b0; m_act = 0;
    endtask

    task automatic arm(input longint unsigned b, input longint unsigned c, input int len);
        tick(1'b1);
        set_times(b, c);
        list_len = LEN_W'(len);
        sched_en = 1'b1;
        m_c = c; m_len = len;
        m_act = (b != 0) && (c != 0) && (len != 0) && (len < DEPTH);
        m_past = (b <= t);
        if (m_act) m_s = first_start(b, t, c);
    endtask

    task automatic load_list(input int len);
        int sum;
        sum = 0;
        for (int i = 0; i < len; i++) begin
            m_ivl[i] = 5 + int'($urandom % 20);
            m_g[i]   = GATE_W'($urandom);
            sum += m_ivl[i];
            put(i, {m_g[i], IVL_W'(m_ivl[i])});
        end
        tick(1'b1);
        wr_en = 1'b0;
    endtask

    initial begin
        int len, sum, off;
        longint unsigned c, b;
        void'($urandom(32'd1234));
        m_act = 0; m_pm = 0;
        t = 5 * BIL - 1500;   // schedules will cross a second boundary (R9)
        drive_time();
        repeat (3) @(negedge clk);
        // reset state: all open, no hold (R2)
        check_now();
        rst_n = 1'b1;

        for (int s = 0; s < 12; s++) begin
            len = 1 + int'($urandom % 8);
            load_list(len);
            sum = 0;
            for (int i = 0; i < len; i++) sum += m_ivl[i];
            if (s % 2 == 0) c = longint'(sum + 15 + int'($urandom % 40));       // R6 tail
            else            c = longint'((sum > 40 ? sum : 40) - 1 - int'($urandom % 15)); // R7 cut
            if (c < 25) c = 25;
            m_pm = s[0] ^ s[1];
            preempt_mode = m_pm;   // R8
            case (s % 3)
                0: b = t + 30 + longint'($urandom % 50);                       // R3 future start
                1: begin                                                       // R4 past start
                    off = int'($urandom % (c - 20));
                    b = t - 2 * c - longint'(off);
                end
                default: b = t - 3 * c;                                        // R4 on a boundary
            endcase
            arm(b, c, len);
            for (int k = 0; k < int'(4 * c) + 60; k++) tick(1'b1);
            disarm();            // R2: all gates open a clock later
            for (int k = 0; k < 4; k++) tick(1'b1);
        end

        // R2 directed: invalid settings keep the gates open
        load_list(3);
        arm(t + 40, 0, 3);          for (int k = 0; k < 60; k++) tick(1'b1); disarm();
        arm(t + 40, 100, 0);        for (int k = 0; k < 60; k++) tick(1'b1); disarm();
        arm(t + 40, 100, DEPTH);    for (int k = 0; k < 60; k++) tick(1'b1); disarm();
        arm(0, 100, 3);             for (int k = 0; k < 60; k++) tick(1'b1); disarm();
        // R2: drop the enable in the middle of a running entry
        m_pm = 1; preempt_mode = 1'b1;
        arm(t + 20, 200, 3);        for (int k = 0; k < 50; k++) tick(1'b1); disarm();
        for (int k = 0; k < 10; k++) tick(1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule